// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block is a watchdog whose whole programming model is one 8-bit register. A register-bus write does three jobs. The first write that carries a zero in the control bit arms the watchdog and fixes the interval. Each later zero in that bit restarts the count. Before arming, writes also load the interval choice. A register-bus read returns four sticky flags that record the last kinds of reset. The read clears those flags as a side effect.

The prescaler supplies two groups of one-cycle tick taps: one group for the slow sub/watch source and one for the main/PLL source. The source select input chooses the group. The latched interval code chooses the tap within that group. A 2-bit counter advances on each pulse of the chosen tap. When it wraps, the block raises a one-cycle reset request and marks the watchdog flag. The system reset sequencer sends pulses back that tell the block which reset took place. Each such pulse, or the block's own overflow, disarms the watchdog and returns the interval code to its default of 0.

All pins are plain control and status signals. The register bus never stalls. A write takes effect at the clock edge where `wr_en` is high. Read data is registered: it appears the cycle after `rd_en` and holds until the next read.

Top module: `wdt_rstcause`

## Requirements
- R1: Read layout: bit 7 is the power-on flag, bit 5 the watchdog flag, bit 4 the external flag and bit 3 the software flag. Bit 6 and bits 2..0 read as 0. `rd_data` shows the flags as they stood at the edge where `rd_en` was high, starting the cycle after that edge.
- R2: After `rst_n` is released, a read returns 8'h80, with only the power-on flag set.
- R3: A read clears all four flags, so a second read with no event between the two returns 8'h00.
- R4: A pulse on `por_evt`, `ext_evt` or `sw_evt` sets bit 7, bit 4 or bit 3 respectively. If the pulse falls in the same cycle as a read, the flag is set and the read's clear does not apply to it.
- R5: While the watchdog is disarmed, a write with bit 2 = 0 arms it, with the interval taken from bits 1..0 of that same write.
- R6: A write with bit 2 = 1 neither arms the watchdog nor clears the counter.
- R7: While armed, a write with bit 2 = 0 clears the counter. If a tick arrives in the same cycle, the clear wins.
- R8: While armed, writes to bits 1..0 are ignored.
- R9: The counter advances only on tap `ivl` of `tick_main` when `src_main` = 1, or of `tick_sub` when `src_main` = 0. All other taps are ignored.
- R10: On the fourth counted tick after arming or the last clear, `wdt_req` goes high for exactly one cycle, the cycle after that tick. The watchdog flag is set. No other flag changes.
- R11: An overflow or any event pulse disarms the watchdog and resets the interval to 0. While disarmed, ticks produce no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data (bit 2 control, bits 1..0 interval) |
| rd_en | input | 1 | Register read strobe; clears the flags |
| rd_data | output | 8 | Registered read data |
| por_evt | input | 1 | Power-on reset happened (pulse) |
| ext_evt | input | 1 | External reset happened (pulse) |
| sw_evt | input | 1 | Software reset happened (pulse) |
| src_main | input | 1 | 1 selects the main/PLL tick group, 0 the sub/watch group |
| tick_sub | input | 4 | Sub/watch interval taps, one-cycle pulses |
| tick_main | input | 4 | Main/PLL interval taps, one-cycle pulses |
| wdt_req | output | 1 | One-cycle watchdog reset request |

## Verification
Two same-cycle collisions matter most. In the first, a read's clear meets a new reset-cause pulse. The bench drives `rd_en` and `sw_evt` together and expects the following read to still show bit 3. In the second, a clearing write meets a counted tick. The bench places the write on the tick's cycle and expects the counter to start over, so that only four further ticks raise `wdt_req`. A random phase then mixes reads, writes, events and ticks freely. A behavioural model judges every cycle of that phase.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BIT_PON = 7;
  localparam int BIT_WDT = 5;
  localparam int BIT_EXT = 4;
  localparam int BIT_SW  = 3;
  localparam int BIT_CTL = 2;
  localparam int REG_W   = 8;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
  parameter int IVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_ctl,
  input  logic [IVL_W-1:0] wr_ivl,
  input  logic             disarm,
  output logic             active,
  output logic [IVL_W-1:0] ivl_q,
  output logic             cnt_clr
);
  // a zero in the control bit is both the arm and the kick command
  assign cnt_clr = wr_en && !wr_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ivl_q  <= '0;
    end else if (disarm) begin
      active <= 1'b0;
      ivl_q  <= '0;
    end else if (wr_en && !active) begin
      ivl_q <= wr_ivl;
      if (!wr_ctl) active <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int IVL_W = 2,
  parameter int CNT_W = 2,
  localparam int TAPS = 1 << IVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             cnt_clr,
  input  logic             evt_rst,
  input  logic             src_main,
  input  logic [IVL_W-1:0] ivl,
  input  logic [TAPS-1:0]  tick_sub,
  input  logic [TAPS-1:0]  tick_main,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [TAPS-1:0] taps;
  logic            tap_hit;

  assign taps    = src_main ? tick_main : tick_sub;
  assign tap_hit = taps[ivl];
  assign ovf     = active && tap_hit && !cnt_clr && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (!active || cnt_clr || evt_rst) cnt_q <= '0;
    else if (tap_hit)                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_cause.sv
module wdt_cause
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             por_evt,
  input  logic             ext_evt,
  input  logic             sw_evt,
  input  logic             ovf,
  output logic             flag_pon,
  output logic             flag_wdt,
  output logic             flag_ext,
  output logic             flag_sw,
  output logic [REG_W-1:0] rd_data
);
  logic [REG_W-1:0] view;

  always_comb begin
    view          = '0;
    view[BIT_PON] = flag_pon;
    view[BIT_WDT] = flag_wdt;
    view[BIT_EXT] = flag_ext;
    view[BIT_SW]  = flag_sw;
  end

  // set has priority over the read-side clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_pon <= 1'b1;
      flag_wdt <= 1'b0;
      flag_ext <= 1'b0;
      flag_sw  <= 1'b0;
      rd_data  <= '0;
    end else begin
      flag_pon <= por_evt | (flag_pon & ~rd_en);
      flag_wdt <= ovf     | (flag_wdt & ~rd_en);
      flag_ext <= ext_evt | (flag_ext & ~rd_en);
      flag_sw  <= sw_evt  | (flag_sw  & ~rd_en);
      if (rd_en) rd_data <= view;
    end
  end
endmodule

// File: rtl/wdt_rstcause.sv
module wdt_rstcause
  import wdt_pkg::*;
#(
  parameter int IVL_W = 2,
  parameter int CNT_W = 2,
  localparam int TAPS = 1 << IVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  input  logic             por_evt,
  input  logic             ext_evt,
  input  logic             sw_evt,
  input  logic             src_main,
  input  logic [TAPS-1:0]  tick_sub,
  input  logic [TAPS-1:0]  tick_main,
  output logic             wdt_req
);
  logic             active, cnt_clr, ovf, evt_rst;
  logic [IVL_W-1:0] ivl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_pon, flag_wdt, flag_ext, flag_sw;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^wr_data[REG_W-1:BIT_CTL+1];
  assign evt_rst        = por_evt | ext_evt | sw_evt;

  wdt_ctrl #(.IVL_W(IVL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctl(wr_data[BIT_CTL]),
    .wr_ivl(wr_data[IVL_W-1:0]), .disarm(evt_rst | ovf),
    .active(active), .ivl_q(ivl_q), .cnt_clr(cnt_clr)
  );

  wdt_counter #(.IVL_W(IVL_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active(active), .cnt_clr(cnt_clr),
    .evt_rst(evt_rst), .src_main(src_main), .ivl(ivl_q),
    .tick_sub(tick_sub), .tick_main(tick_main), .cnt_q(cnt_q), .ovf(ovf)
  );

  wdt_cause u_cause (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .por_evt(por_evt),
    .ext_evt(ext_evt), .sw_evt(sw_evt), .ovf(ovf),
    .flag_pon(flag_pon), .flag_wdt(flag_wdt), .flag_ext(flag_ext),
    .flag_sw(flag_sw), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_req <= 1'b0;
    else        wdt_req <= ovf;
  end
endmodule

// File: rtl/wdt_rstcause_chk.sv
module wdt_rstcause_chk #(
  parameter int IVL_W = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             rd_en,
  input logic             por_evt,
  input logic             ext_evt,
  input logic             sw_evt,
  input logic             wdt_req,
  input logic             active,
  input logic [IVL_W-1:0] ivl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag_pon,
  input logic             flag_wdt,
  input logic             flag_ext,
  input logic             flag_sw
);
  // R10
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_req |=> !wdt_req);
  // R10
  req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_req |-> flag_wdt);
  // R11
  req_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_req |-> !active);
  // R11
  idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> cnt_q == '0);
  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !por_evt && !ext_evt && !sw_evt) |=> (!flag_pon && !flag_ext && !flag_sw));
  // R4
  ext_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> flag_ext);
  // R7
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_en && !wr_data[2]) |=> cnt_q == '0);
  // R8
  ivl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(ivl_q));
endmodule

bind wdt_rstcause wdt_rstcause_chk #(.IVL_W(IVL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .por_evt(por_evt), .ext_evt(ext_evt), .sw_evt(sw_evt), .wdt_req(wdt_req),
  .active(active), .ivl_q(ivl_q), .cnt_q(cnt_q), .flag_pon(flag_pon),
  .flag_wdt(flag_wdt), .flag_ext(flag_ext), .flag_sw(flag_sw)
);

// File: tb/tb_wdt_rstcause.sv
module tb_wdt_rstcause;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 0, rd_en = 0, por_evt = 0, ext_evt = 0, sw_evt = 0, src_main = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] tick_sub = 0, tick_main = 0;
  logic [7:0] rd_data;
  logic       wdt_req;

  int checks = 0, errors = 0;
  string tag = "R2";

  wdt_rstcause dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .por_evt(por_evt), .ext_evt(ext_evt), .sw_evt(sw_evt),
    .src_main(src_main), .tick_sub(tick_sub), .tick_main(tick_main), .wdt_req(wdt_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_act, m_ivl, m_cnt, m_pon, m_wdt, m_ext, m_sw, m_req;
  logic [7:0] m_rd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_ivl = 0; m_cnt = 0; m_pon = 1; m_wdt = 0; m_ext = 0; m_sw = 0;
      m_req = 0; m_rd = 0;
    end else begin
      bit tap, kick, ovf, evt;
      tap  = src_main ? tick_main[m_ivl] : tick_sub[m_ivl];
      kick = wr_en && !wr_data[2];
      ovf  = m_act != 0 && tap && !kick && m_cnt == 3;
      evt  = por_evt || ext_evt || sw_evt;
      if (rd_en) begin
        m_rd = {m_pon[0], 1'b0, m_wdt[0], m_ext[0], m_sw[0], 3'b000};
        m_pon = 0; m_wdt = 0; m_ext = 0; m_sw = 0;
      end
      if (por_evt) m_pon = 1;
      if (ext_evt) m_ext = 1;
      if (sw_evt)  m_sw = 1;
      if (ovf)     m_wdt = 1;
      if (m_act == 0 || kick || evt) m_cnt = 0;
      else if (tap) m_cnt = (m_cnt + 1) % 4;
      if (evt || ovf) begin m_act = 0; m_ivl = 0; end
      else if (wr_en && m_act == 0) begin
        m_ivl = wr_data[1:0];
        if (!wr_data[2]) m_act = 1;
      end
      m_req = ovf ? 1 : 0;
    end
  end

  task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check({tag, " wdt_req"}, {7'd0, wdt_req}, m_req[7:0]);
    check({tag, " rd_data"}, rd_data, m_rd);
  end

  task automatic cyc(input logic w, input logic [7:0] d, input logic r,
                     input logic p, input logic e, input logic s,
                     input logic [3:0] ts, input logic [3:0] tm);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; por_evt = p; ext_evt = e; sw_evt = s;
    tick_sub = ts; tick_main = tm;
  endtask

  task automatic idle(); cyc(0, 8'h00, 0, 0, 0, 0, 4'h0, 4'h0); endtask
  task automatic rd();   cyc(0, 8'h00, 1, 0, 0, 0, 4'h0, 4'h0); idle(); endtask
  task automatic tk(input logic [3:0] ts, input logic [3:0] tm);
    cyc(0, 8'h00, 0, 0, 0, 0, ts, tm); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R2"; rd(); check("R2 reset read", rd_data, 8'h80);
    tag = "R3"; rd(); check("R3 cleared", rd_data, 8'h00);
    tag = "R4"; cyc(0, 0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0, 1, 0, 0); rd();
    check("R4 ext+sw", rd_data, 8'h18);
    cyc(0, 0, 1, 0, 0, 1, 0, 0); idle(); rd(); check("R4 set beats clear", rd_data, 8'h08);
    tag = "R6"; cyc(1, 8'h04, 0, 0, 0, 0, 0, 0);
    repeat (5) tk(4'h1, 4'h0);
    check("R6 no arm", {7'd0, wdt_req}, 8'h00);
    tag = "R5"; cyc(1, 8'h02, 0, 0, 0, 0, 0, 0);
    tag = "R9"; repeat (4) tk(4'hB, 4'h4);
    tag = "R10"; repeat (3) tk(4'h4, 0);
    cyc(0, 0, 0, 0, 0, 0, 4'h4, 0);
    idle(); check("R10 request", {7'd0, wdt_req}, 8'h01);
    idle(); check("R10 single cycle", {7'd0, wdt_req}, 8'h00);
    rd(); check("R10 wdt flag only", rd_data, 8'h20);
    tag = "R11"; repeat (5) tk(4'hF, 4'hF);
    tag = "R7"; cyc(1, 8'h00, 0, 0, 0, 0, 0, 0);
    repeat (3) tk(4'h1, 0);
    cyc(1, 8'h00, 0, 0, 0, 0, 4'h1, 0);
    repeat (3) tk(4'h1, 0);
    check("R7 clear wins", {7'd0, wdt_req}, 8'h00);
    tk(4'h1, 0); check("R7 fourth after clear", {7'd0, wdt_req}, 8'h01);
    tag = "R8"; cyc(1, 8'h01, 0, 0, 0, 0, 0, 0); cyc(1, 8'h03, 0, 0, 0, 0, 0, 0);
    repeat (4) tk(4'h8, 0);
    repeat (4) tk(4'h2, 0);
    tag = "R9"; src_main = 1; cyc(1, 8'h03, 0, 0, 0, 0, 0, 0);
    repeat (4) tk(4'h8, 4'h8);
    tag = "R11"; cyc(1, 8'h00, 0, 0, 0, 0, 0, 0); tk(4'h1, 4'h1);
    cyc(0, 0, 0, 1, 0, 0, 0, 0); repeat (6) tk(4'h1, 4'h1);
    rd(); check("R11 por flag", rd_data & 8'h80, 8'h80);
    tag = "R1";
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      int u;
      d = 8'($urandom);
      u = $urandom % 100;
      src_main = (i % 512) < 256;
      cyc(u < 6, d, u >= 6 && u < 12, u == 12, u == 13, u == 14,
          4'($urandom), 4'($urandom));
    end
    idle(); idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule